// File: doc/BRIEF.md
# OFDM Cyclic Prefix and Preamble Framer

This block sits at the end of an OFDM transmit chain and takes time-domain symbols of 64 samples each. It sends every symbol out with a 16-sample guard copied from the end of that same symbol. Ahead of the first symbol of each packet it sends a fixed 320-sample training preamble, which it computes internally. Symbols come in on a valid/ready stream. They go into one of two 64-entry banks, so the next symbol can be written while the current one is read out. When both banks still hold unread symbols, the block holds back the source.

The output side runs on a fabric clock eight times the highest sample rate. A pace strobe from outside gates each output sample, and lowering the strobe's duty cycle lowers the effective bandwidth. An internal spacing counter makes sure consecutive samples are never closer than the minimum gap. A done flag marks the final sample of a packet.

Top module: `ofdm_framer`

## Requirements
- R1: After reset, `out_valid`, `out_pkt_done` and `out_data` are all zero and `in_ready` is one.
- R2: An input sample is taken on every rising edge where `in_valid` and `in_ready` are both high. Each run of 64 accepted samples forms one symbol, in input order. `in_first` is sampled on the symbol's first accepted sample and marks the start of a packet. `in_last` is sampled on the symbol's 64th sample and marks the final symbol of a packet.
- R3: A symbol marked as a packet start is preceded by 320 preamble samples. Preamble sample k (k = 0..319) has bits [31:16] = (29·k + 7) mod 65536 and bits [15:0] = k XOR 0x00FF.
- R4: Each symbol is emitted as 80 samples: its samples 48 through 63, then its samples 0 through 63.
- R5: `out_valid` is high only in the cycle after a cycle in which `pace` was high.
- R6: Two output samples are never less than 8 clock cycles apart. With `pace` held high and data ready, they are exactly 8 cycles apart.
- R7: While `out_valid` is low, `out_data` is zero.
- R8: `in_ready` is low exactly when both banks hold unread symbols. If no output is taken, the block accepts 128 samples and then holds the source back.
- R9: `out_pkt_done` is high together with the last sample of a symbol marked final, and at no other time.
- R10: Each new packet starts again with the full preamble, even when it directly follows the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (8x maximum sample rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| pace | input | 1 | Sample-rate strobe; an output sample may follow a high cycle |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 32 | Input sample, I in [31:16], Q in [15:0] |
| in_first | input | 1 | First sample of a packet |
| in_last | input | 1 | Last sample of a packet |
| out_valid | output | 1 | Output sample present |
| out_data | output | 32 | Output sample, zero when not valid |
| out_pkt_done | output | 1 | Final sample of the packet |

## Verification
The assertions check four rules on every cycle: output only follows a pace cycle, consecutive emissions are never back to back, output stays zero and the done flag stays low while idle, and back-pressure happens only with both banks full. The correct content and order of the preamble, guard and body samples can only be shown by the bench's scoreboard scenarios. The same holds for exact 8-cycle spacing under a steady strobe, the 128-sample fill limit, and the placement of the done flag.

// File: rtl/ofdm_framer_pkg.sv
`timescale 1ns/1ps
package ofdm_framer_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_CP, ST_BODY} rd_state_e;
   // preamble generator constants: I = k*MUL + ADD, Q = k ^ XOR
   localparam int PRE_MUL = 29;
   localparam int PRE_ADD = 7;
   localparam int PRE_XOR = 'h00FF;
endpackage

// File: rtl/ofdm_framer_buf.sv
`timescale 1ns/1ps
module ofdm_framer_buf #(
   parameter int SW    = 32,
   parameter int N_FFT = 64,
   localparam int AW   = $clog2(N_FFT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [SW-1:0] in_data,
   input  logic          in_first,
   input  logic          in_last,
   input  logic          rd_bank,
   input  logic [AW-1:0] rd_addr,
   input  logic          rel,
   output logic [SW-1:0] rd_data,
   output logic [1:0]    full,
   output logic [1:0]    bank_first,
   output logic [1:0]    bank_last
);
   logic          wr_sel;
   logic [AW-1:0] wr_cnt;
   logic          acc;
   logic [1:0][SW-1:0] rd_word;

   assign in_ready = !full[wr_sel];
   assign acc      = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_sel <= 1'b0;
         wr_cnt <= '0;
      end else if (acc) begin
         wr_cnt <= wr_cnt + 1'b1;
         if (wr_cnt == AW'(N_FFT-1)) wr_sel <= ~wr_sel;
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [SW-1:0] mem [N_FFT];
      logic          full_q, first_q, last_q;
      logic          hit;
      assign hit = acc && (wr_sel == 1'(b));

      always_ff @(posedge clk) begin
         if (hit) mem[wr_cnt] <= in_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q  <= 1'b0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
         end else begin
            if (hit && wr_cnt == '0) first_q <= in_first;
            if (hit && wr_cnt == AW'(N_FFT-1)) begin
               full_q <= 1'b1;
               last_q <= in_last;
            end else if (rel && rd_bank == 1'(b)) begin
               full_q <= 1'b0;
            end
         end
      end

      assign full[b]       = full_q;
      assign bank_first[b] = first_q;
      assign bank_last[b]  = last_q;
      assign rd_word[b]    = mem[rd_addr];
   end

   assign rd_data = rd_word[rd_bank];

   // R8: the source is held only when both banks carry unread symbols
   assert_stall_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (full == 2'b11));
   // R4: a bank is released only after it was filled
   assert_release_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rel |-> full[rd_bank]);
endmodule

// File: rtl/ofdm_framer_pacer.sv
`timescale 1ns/1ps
module ofdm_framer_pacer #(
   parameter int MIN_GAP = 8,
   parameter bit ENFORCE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pace,
   input  logic busy,
   output logic step
);
   if (ENFORCE && MIN_GAP > 1) begin : g_gap
      localparam int GW = $clog2(MIN_GAP);
      logic [GW-1:0] gap_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          gap_cnt <= GW'(MIN_GAP-1);
         else if (step)                       gap_cnt <= '0;
         else if (gap_cnt != GW'(MIN_GAP-1))  gap_cnt <= gap_cnt + 1'b1;
      end
      assign step = busy && pace && (gap_cnt == GW'(MIN_GAP-1));

      // R6: two emissions never fall on adjacent cycles
      assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
         step |=> !step);
   end else begin : g_free
      assign step = busy && pace;
   end

   // R5: no emission without a pace strobe or while nothing is queued
   assert_step_needs_pace_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pace || !busy) |-> !step);
endmodule

// File: rtl/ofdm_framer_seq.sv
`timescale 1ns/1ps
module ofdm_framer_seq
   import ofdm_framer_pkg::*;
#(
   parameter int IQ_W  = 16,
   parameter int N_FFT = 64,
   parameter int N_CP  = 16,
   parameter int N_PRE = 320,
   localparam int SW   = 2*IQ_W,
   localparam int AW   = $clog2(N_FFT),
   localparam int CW   = $clog2(N_PRE > N_FFT ? N_PRE : N_FFT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [1:0]    full,
   input  logic [1:0]    bank_first,
   input  logic [1:0]    bank_last,
   input  logic [SW-1:0] rd_data,
   output logic          busy,
   output logic          rd_bank,
   output logic [AW-1:0] rd_addr,
   output logic          rel,
   output logic          out_valid,
   output logic [SW-1:0] out_data,
   output logic          out_pkt_done
);
   rd_state_e     state;
   logic [CW-1:0] cnt;
   logic          rd_sel;
   logic [IQ_W-1:0] pre_i, pre_q;
   logic [SW-1:0]   sample;

   assign busy    = (state != ST_IDLE);
   assign rd_bank = rd_sel;
   assign rd_addr = (state == ST_CP) ? AW'(N_FFT-N_CP) + AW'(cnt) : AW'(cnt);
   assign rel     = step && (state == ST_BODY) && (cnt == CW'(N_FFT-1));

   assign pre_i  = IQ_W'(32'(cnt) * PRE_MUL + PRE_ADD);
   assign pre_q  = IQ_W'(cnt) ^ IQ_W'(PRE_XOR);
   assign sample = (state == ST_PRE) ? {pre_i, pre_q} : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         rd_sel <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (full[rd_sel]) begin
               state <= bank_first[rd_sel] ? ST_PRE : ST_CP;
               cnt   <= '0;
            end
            ST_PRE: if (step) begin
               if (cnt == CW'(N_PRE-1)) begin state <= ST_CP; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            ST_CP: if (step) begin
               if (cnt == CW'(N_CP-1)) begin state <= ST_BODY; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            ST_BODY: if (step) begin
               if (cnt == CW'(N_FFT-1)) begin
                  state  <= ST_IDLE;
                  cnt    <= '0;
                  rd_sel <= ~rd_sel;
               end else cnt <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_pkt_done <= 1'b0;
      end else begin
         out_valid    <= step;
         out_data     <= step ? sample : '0;
         out_pkt_done <= rel && bank_last[rd_sel];
      end
   end

   // R4: readout waits in idle until the next bank is filled
   assert_wait_for_symbol_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !full[rd_sel]) |=> (state == ST_IDLE));
endmodule

// File: rtl/ofdm_framer.sv
`timescale 1ns/1ps
module ofdm_framer #(
   parameter int IQ_W    = 16,
   parameter int N_FFT   = 64,
   parameter int N_CP    = 16,
   parameter int N_PRE   = 320,
   parameter int MIN_GAP = 8,
   parameter bit ENFORCE_GAP = 1'b1,
   localparam int SW     = 2*IQ_W,
   localparam int AW     = $clog2(N_FFT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pace,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [SW-1:0] in_data,
   input  logic          in_first,
   input  logic          in_last,
   output logic          out_valid,
   output logic [SW-1:0] out_data,
   output logic          out_pkt_done
);
   if ((1 << AW) != N_FFT) begin : g_bad_fft
      $error("N_FFT must be a power of two");
   end
   if (N_CP < 1 || N_CP > N_FFT) begin : g_bad_cp
      $error("N_CP must lie in 1..N_FFT");
   end
   if (N_PRE < 1 || MIN_GAP < 1) begin : g_bad_pre
      $error("N_PRE and MIN_GAP must be positive");
   end

   logic          rd_bank, rel, busy, step;
   logic [AW-1:0] rd_addr;
   logic [SW-1:0] rd_data;
   logic [1:0]    full, bank_first, bank_last;

   ofdm_framer_buf #(.SW(SW), .N_FFT(N_FFT)) buf_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .rd_bank(rd_bank), .rd_addr(rd_addr), .rel(rel), .rd_data(rd_data),
      .full(full), .bank_first(bank_first), .bank_last(bank_last));

   ofdm_framer_pacer #(.MIN_GAP(MIN_GAP), .ENFORCE(ENFORCE_GAP)) pacer_i (
      .clk(clk), .rst_n(rst_n), .pace(pace), .busy(busy), .step(step));

   ofdm_framer_seq #(.IQ_W(IQ_W), .N_FFT(N_FFT), .N_CP(N_CP), .N_PRE(N_PRE)) seq_i (
      .clk(clk), .rst_n(rst_n), .step(step), .full(full),
      .bank_first(bank_first), .bank_last(bank_last), .rd_data(rd_data),
      .busy(busy), .rd_bank(rd_bank), .rd_addr(rd_addr), .rel(rel),
      .out_valid(out_valid), .out_data(out_data), .out_pkt_done(out_pkt_done));

   // R5: a sample at the port always follows a strobe cycle
   assert_paced_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pace |=> !out_valid);
   // R7: idle output carries zero
   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == '0));
   // R9: the done flag only rides on a real sample
   assert_done_with_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_pkt_done |-> out_valid);
endmodule

// File: tb/ofdm_framer_tb_top.sv
`timescale 1ns/1ps
module ofdm_framer_tb_top;
   localparam int SW = 32, N_FFT = 64, N_CP = 16, N_PRE = 320, MIN_GAP = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, pace = 1'b0, in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [SW-1:0] in_data = '0;
   logic in_ready, out_valid, out_pkt_done;
   logic [SW-1:0] out_data;

   ofdm_framer dut_i (
      .clk(clk), .rst_n(rst_n), .pace(pace), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .out_valid(out_valid), .out_data(out_data), .out_pkt_done(out_pkt_done));

   logic [SW-1:0] exp_d[$];
   bit            exp_done[$];
   string         exp_req[$];
   int checks = 0, failures = 0;
   int pace_mode = 0, pc = 0, cyc = 0, last_t = -1, acc_cnt = 0;
   bit strict = 1'b0, prev_pace = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [SW-1:0] pre_val(input int k);
      logic [15:0] i_part, q_part;
      i_part = 16'((k * 29 + 7) & 'hFFFF);
      q_part = 16'(k) ^ 16'h00FF;
      return {i_part, q_part};
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // pace strobe: 0 = off, 1 = every cycle, n > 1 = one cycle in n
   initial forever begin
      @(posedge clk); #1;
      pc++;
      if (pace_mode == 0)      pace = 1'b0;
      else if (pace_mode == 1) pace = 1'b1;
      else                     pace = (pc % pace_mode == 0);
   end

   // monitor: pops the scoreboard on every emitted sample
   initial forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
         if (out_valid) begin
            check(prev_pace, "R5", "sample without strobe", 0, 1);
            if (last_t >= 0) begin
               check(cyc - last_t >= MIN_GAP, "R6", "spacing too short", cyc - last_t, MIN_GAP);
               if (strict)
                  check(cyc - last_t == MIN_GAP, "R6", "steady spacing", cyc - last_t, MIN_GAP);
            end
            last_t = cyc;
            if (exp_d.size() == 0) begin
               check(1'b0, "R4", "unexpected sample", out_data, 0);
            end else begin
               automatic logic [SW-1:0] d = exp_d.pop_front();
               automatic bit dn = exp_done.pop_front();
               automatic string rq = exp_req.pop_front();
               check(out_data == d, rq, "sample value", out_data, d);
               check(out_pkt_done == dn, "R9", "done flag", out_pkt_done, dn);
            end
         end else begin
            check(out_data == '0, "R7", "idle data", out_data, 0);
            check(!out_pkt_done, "R9", "done while idle", out_pkt_done, 0);
         end
         if (in_valid && in_ready) acc_cnt++;
      end
      prev_pace = pace;
   end

   // driver: pushes expected items, then streams the symbols in
   task automatic send_packet(input int nsym, input logic [15:0] tag);
      for (int k = 0; k < N_PRE; k++) begin   // R3, R10: preamble on every packet
         exp_d.push_back(pre_val(k)); exp_done.push_back(1'b0); exp_req.push_back("R3 R10");
      end
      for (int s = 0; s < nsym; s++) begin
         for (int j = N_FFT - N_CP; j < N_FFT; j++) begin
            exp_d.push_back({tag, 16'(s*N_FFT + j)}); exp_done.push_back(1'b0);
            exp_req.push_back("R4 guard");
         end
         for (int j = 0; j < N_FFT; j++) begin
            exp_d.push_back({tag, 16'(s*N_FFT + j)});
            exp_done.push_back(s == nsym-1 && j == N_FFT-1);
            exp_req.push_back("R4 R2 body");
         end
      end
      for (int s = 0; s < nsym; s++) begin
         for (int i = 0; i < N_FFT; i++) begin
            automatic bit ok;
            in_valid = 1'b1;
            in_data  = {tag, 16'(s*N_FFT + i)};
            in_first = (s == 0 && i == 0);
            in_last  = (s == nsym-1 && i == N_FFT-1);
            do begin
               @(negedge clk); ok = in_ready;
               @(posedge clk);
            end while (!ok);
            #1;
         end
      end
      in_valid = 1'b0; in_data = '0; in_first = 1'b0; in_last = 1'b0;
   endtask

   task automatic drain();
      for (int n = 0; n < 20000 && exp_d.size() != 0; n++) @(negedge clk);
      check(exp_d.size() == 0, "R4", "scoreboard drained", exp_d.size(), 0);
      repeat (20) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R4", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
      check(out_data == '0, "R1", "reset out_data", out_data, 0);
      check(out_pkt_done == 1'b0, "R1", "reset done", out_pkt_done, 0);
      check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
      @(posedge clk); #1;

      // steady strobe, two back-to-back packets (R6 exact spacing, R10)
      strict = 1'b1; pace_mode = 1;
      send_packet(2, 16'h1111);
      send_packet(2, 16'h2222);
      drain();
      strict = 1'b0;

      // reduced bandwidth: strobe once every ten cycles
      last_t = -1; pace_mode = 10;
      send_packet(1, 16'h3333);
      drain();

      // back-pressure with the strobe stopped (R8)
      pace_mode = 0;
      repeat (2) @(posedge clk);
      #1; acc_cnt = 0; last_t = -1;
      fork
         send_packet(3, 16'h4444);
      join_none
      repeat (400) @(posedge clk);
      @(negedge clk);
      check(acc_cnt == 2*N_FFT, "R8", "samples taken before stall", acc_cnt, 2*N_FFT);
      check(in_ready == 1'b0, "R8", "in_ready while both banks full", in_ready, 0);
      check(out_valid == 1'b0, "R5", "no output with strobe off", out_valid, 0);
      @(posedge clk); #1;
      pace_mode = 3;
      wait fork;
      drain();
      finish_run();
   end
endmodule